// File: doc/BRIEF.md
# Fixed-Vector Interrupt Priority Unit

This block sits beside a small 8-bit processor core and merges five hardware interrupt request lines into one service request. Each line has its own trigger rule. One line cannot be masked and fires only when a rising edge is followed by a held high level. One vectored line is edge-only, and its edge is held in a sticky latch. Two vectored lines are level-sensitive. The last line is a general, non-vectored request. The block applies a global enable and per-line masks, picks the single highest-priority active line, and tells the core where to go.

For a vectored winner the block drives a fixed 16-bit address. Every fixed address is four times a "half-index", so the set is 0x0024, 0x003C, 0x0034 and 0x002C. For the general line the block sets a flag instead, and an outside device then supplies the address. The core pulses `ack` when it takes the interrupt. That pulse clears the winning line's edge latch, if it has one. When the winner is maskable, the pulse also clears the global enable.

The enable and the mask bits are state held inside the block. The core changes them through set/clear strobes and a mask write port.

Top module: `irq_prio_unit`

## Requirements
- R1: After reset, `irq_pend`, `vec_valid` and `vec_ext` are 0. The global enable is 0 and all three mask bits are 1. Maskable requests therefore raise nothing until software changes this state.
- R2: The non-maskable line is serviced with vector 0x0024, whatever the values of the global enable and the masks. It is accepted one clock after a rising edge, provided the input is still high.
- R3: The non-maskable request counts only while its latched edge and its current high level are both present. Dropping the input withdraws the request. After `ack`, a line that stays high does not request again until it shows a fresh rising edge.
- R4: Priority runs from highest to lowest: non-maskable, edge line (0x003C), high level line (0x0034), low level line (0x002C), general line. At most one of `vec_valid` and `vec_ext` is 1, and `irq_pend` equals their OR.
- R5: A rising edge on `req_edge` is latched. The request stays pending with vector 0x003C after the input returns low.
- R6: The edge latch captures an edge even while its mask bit or the global enable blocks it. Unblocking then raises the request.
- R7: `req_lvl_hi` and `req_lvl_lo` request only while they are high. Their vectors are 0x0034 and 0x002C.
- R8: When the general line wins, `vec_ext`=1, `vec_valid`=0 and `vec_addr`=0. This line obeys the global enable but has no mask bit.
- R9: While the global enable is 0, no maskable line raises `irq_pend`. `ie_set` sets the enable and `ie_clr` clears it.
- R10: A write through `mask_we` stores `mask_wdata`. Bit 2 masks the edge line, bit 1 the high level line and bit 0 the low level line. A 1 blocks the line.
- R11: An `ack` while a maskable line wins clears the global enable. An `ack` of the non-maskable line leaves the enable unchanged.
- R12: The edge latch is cleared by an `ack` while it wins, and by an `edge_clr` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_nmi | input | 1 | Non-maskable request (edge and level) |
| req_edge | input | 1 | Edge-triggered vectored request |
| req_lvl_hi | input | 1 | Level vectored request, higher priority |
| req_lvl_lo | input | 1 | Level vectored request, lower priority |
| req_ext | input | 1 | General non-vectored level request |
| ie_set | input | 1 | Set global enable |
| ie_clr | input | 1 | Clear global enable |
| mask_we | input | 1 | Write mask bits |
| mask_wdata | input | 3 | New mask bits (1 = blocked) |
| edge_clr | input | 1 | Software clear of the edge latch |
| ack | input | 1 | Core acknowledge strobe |
| irq_pend | output | 1 | An interrupt is pending |
| vec_valid | output | 1 | `vec_addr` holds a fixed vector |
| vec_ext | output | 1 | The vector must come from an external device |
| vec_addr | output | 16 | Fixed vector address |

## Verification
The hardest states to reach are the ones that depend on history rather than on present inputs. Examples are an edge latch set while its line was blocked, a non-maskable line still held high after its acknowledge, and a global enable cleared by an acknowledge rather than by software. The bench reaches each of these with a scripted sequence of pulses. It then checks the outputs after each step. It also sweeps every combination of enable, mask and level-line inputs, and compares the winner with a priority computed arithmetically.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int VEC_W  = 16;
    localparam int MASK_W = 3;
    localparam int NSRC   = 5;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_NMI  = 3'd1,
        SRC_EDGE = 3'd2,
        SRC_LHI  = 3'd3,
        SRC_LLO  = 3'd4,
        SRC_EXT  = 3'd5
    } irq_src_e;

    typedef struct packed {
        irq_src_e           src;
        logic               fixed;
        logic               ext;
        logic [VEC_W-1:0]   vec;
    } irq_grant_t;

    // Every fixed vector is four times its half-index.
    function automatic logic [VEC_W-1:0] vec_of(irq_src_e s);
        int half;
        case (s)
            SRC_NMI:  half = 9;
            SRC_EDGE: half = 15;
            SRC_LHI:  half = 13;
            SRC_LLO:  half = 11;
            default:  half = 0;
        endcase
        return VEC_W'(half * 4);
    endfunction

endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic clr,
    output logic lat
);
    logic prev_q;
    logic rise;

    assign rise = din & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            lat    <= 1'b0;
        end else begin
            prev_q <= din;
            if (rise)
                lat <= 1'b1;
            else if (clr)
                lat <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ie_set,
    input  logic              ie_clr,
    input  logic              ack_maskable,
    input  logic              mask_we,
    input  logic [MASK_W-1:0] mask_wdata,
    output logic              ie_q,
    output logic [MASK_W-1:0] mask_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q   <= 1'b0;
            mask_q <= '1;
        end else begin
            if (ie_clr || ack_maskable)
                ie_q <= 1'b0;
            else if (ie_set)
                ie_q <= 1'b1;
            if (mask_we)
                mask_q <= mask_wdata;
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
(
    input  logic              nmi_lat,
    input  logic              nmi_lvl,
    input  logic              edge_lat,
    input  logic              lvl_hi,
    input  logic              lvl_lo,
    input  logic              ext_lvl,
    input  logic              ie,
    input  logic [MASK_W-1:0] mask,
    output irq_grant_t        grant
);
    logic [MASK_W-1:0] vreq;
    logic [NSRC-1:0]   act;
    logic [2:0]        win;
    logic              any;

    // Vectored maskable lines in priority order.
    assign vreq = {lvl_lo, lvl_hi, edge_lat};

    assign act[0] = nmi_lat & nmi_lvl;

    for (genvar g = 0; g < MASK_W; g++) begin : g_mask
        assign act[1+g] = ie & ~mask[MASK_W-1-g] & vreq[g];
    end

    assign act[NSRC-1] = ie & ext_lvl;

    always_comb begin
        win = 3'd0;
        any = 1'b0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (act[i]) begin
                win = 3'(i);
                any = 1'b1;
            end
        end
    end

    always_comb begin
        grant       = '0;
        grant.src   = SRC_NONE;
        if (any) begin
            grant.src   = irq_src_e'(win + 3'd1);
            grant.ext   = (grant.src == SRC_EXT);
            grant.fixed = !grant.ext;
            grant.vec   = vec_of(grant.src);
        end
    end
endmodule

// File: rtl/irq_prio_unit.sv
module irq_prio_unit
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_nmi,
    input  logic              req_edge,
    input  logic              req_lvl_hi,
    input  logic              req_lvl_lo,
    input  logic              req_ext,
    input  logic              ie_set,
    input  logic              ie_clr,
    input  logic              mask_we,
    input  logic [MASK_W-1:0] mask_wdata,
    input  logic              edge_clr,
    input  logic              ack,
    output logic              irq_pend,
    output logic              vec_valid,
    output logic              vec_ext,
    output logic [VEC_W-1:0]  vec_addr
);
    logic              nmi_lat;
    logic              edge_lat;
    logic              ie_q;
    logic [MASK_W-1:0] mask_q;
    logic              ack_nmi;
    logic              ack_edge;
    logic              ack_maskable;
    irq_grant_t        grant;

    assign ack_nmi      = ack && (grant.src == SRC_NMI);
    assign ack_edge     = ack && (grant.src == SRC_EDGE);
    assign ack_maskable = ack && (grant.src != SRC_NONE) && (grant.src != SRC_NMI);

    irq_edge_latch u_nmi_latch (
        .clk (clk),
        .rst (rst),
        .din (req_nmi),
        .clr (ack_nmi),
        .lat (nmi_lat)
    );

    irq_edge_latch u_edge_latch (
        .clk (clk),
        .rst (rst),
        .din (req_edge),
        .clr (ack_edge | edge_clr),
        .lat (edge_lat)
    );

    irq_ctrl_regs u_regs (
        .clk          (clk),
        .rst          (rst),
        .ie_set       (ie_set),
        .ie_clr       (ie_clr),
        .ack_maskable (ack_maskable),
        .mask_we      (mask_we),
        .mask_wdata   (mask_wdata),
        .ie_q         (ie_q),
        .mask_q       (mask_q)
    );

    irq_arbiter u_arb (
        .nmi_lat  (nmi_lat),
        .nmi_lvl  (req_nmi),
        .edge_lat (edge_lat),
        .lvl_hi   (req_lvl_hi),
        .lvl_lo   (req_lvl_lo),
        .ext_lvl  (req_ext),
        .ie       (ie_q),
        .mask     (mask_q),
        .grant    (grant)
    );

    assign vec_valid = grant.fixed;
    assign vec_ext   = grant.ext;
    assign irq_pend  = grant.fixed | grant.ext;
    assign vec_addr  = grant.vec;
endmodule

// File: rtl/irq_prio_sva.sv
module irq_prio_sva (
    input logic        clk,
    input logic        rst,
    input logic        ack,
    input logic        req_nmi,
    input logic        edge_clr,
    input logic        irq_pend,
    input logic        vec_valid,
    input logic        vec_ext,
    input logic [15:0] vec_addr,
    input logic        ie_q,
    input logic        edge_lat
);
    p_one_kind_r4: assert property (@(posedge clk) disable iff (rst)
        ($countones({vec_valid, vec_ext}) <= 1) && (irq_pend == (vec_valid | vec_ext)));

    p_ext_no_addr_r8: assert property (@(posedge clk) disable iff (rst)
        vec_ext |-> (!vec_valid && vec_addr == 16'h0000));

    p_nmi_needs_level_r3: assert property (@(posedge clk) disable iff (rst)
        !req_nmi |-> !(vec_valid && vec_addr == 16'h0024));

    p_ie_gate_r9: assert property (@(posedge clk) disable iff (rst)
        (!ie_q && !req_nmi) |-> !irq_pend);

    p_ack_drops_ie_r11: assert property (@(posedge clk) disable iff (rst)
        (ack && irq_pend && !(vec_valid && vec_addr == 16'h0024)) |=> !ie_q);

    p_edge_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (edge_lat && !ack && !edge_clr) |=> edge_lat);
endmodule

bind irq_prio_unit irq_prio_sva u_sva (
    .clk       (clk),
    .rst       (rst),
    .ack       (ack),
    .req_nmi   (req_nmi),
    .edge_clr  (edge_clr),
    .irq_pend  (irq_pend),
    .vec_valid (vec_valid),
    .vec_ext   (vec_ext),
    .vec_addr  (vec_addr),
    .ie_q      (ie_q),
    .edge_lat  (edge_lat)
);

// File: tb/test_irq_prio_unit.sv
module test_irq_prio_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_nmi = 0, req_edge = 0, req_lvl_hi = 0, req_lvl_lo = 0, req_ext = 0;
    logic        ie_set = 0, ie_clr = 0, mask_we = 0, edge_clr = 0, ack = 0;
    logic [2:0]  mask_wdata = 3'b111;
    logic        irq_pend, vec_valid, vec_ext;
    logic [15:0] vec_addr;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 0;

    always #5 clk = ~clk;

    irq_prio_unit i_irq_prio_unit (
        .clk, .rst, .req_nmi, .req_edge, .req_lvl_hi, .req_lvl_lo, .req_ext,
        .ie_set, .ie_clr, .mask_we, .mask_wdata, .edge_clr, .ack,
        .irq_pend, .vec_valid, .vec_ext, .vec_addr
    );

    // Expected outputs packed as {pend, valid, ext, addr}.
    task automatic expect_out(string req, logic p, logic v, logic e, logic [15:0] a);
        n_checks++;
        if ({irq_pend, vec_valid, vec_ext, vec_addr} !== {p, v, e, a}) begin
            n_fail++;
            $display("FAIL %s: got pend=%0b valid=%0b ext=%0b addr=%h, expected pend=%0b valid=%0b ext=%0b addr=%h",
                     req, irq_pend, vec_valid, vec_ext, vec_addr, p, v, e, a);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pulse_ack();
        ack = 1; tick(); ack = 0;
    endtask

    task automatic set_ie(logic on);
        ie_set = on; ie_clr = !on; tick(); ie_set = 0; ie_clr = 0;
    endtask

    task automatic set_mask(logic [2:0] m);
        mask_we = 1; mask_wdata = m; tick(); mask_we = 0;
    endtask

    initial begin
        repeat (3) tick();
        rst = 0;
        tick();
        // R1: idle outputs after reset
        expect_out("R1", 0, 0, 0, 16'h0);
        // R1: enable clear and masks set at reset, so maskable lines stay quiet
        req_lvl_hi = 1; req_lvl_lo = 1; req_ext = 1;
        tick();
        expect_out("R1", 0, 0, 0, 16'h0);
        req_lvl_hi = 0; req_lvl_lo = 0; req_ext = 0;

        // Sweep of enable x mask x level lines (R7, R8, R9, R10)
        for (int e = 0; e < 2; e++) begin
            for (int m = 0; m < 8; m++) begin
                for (int l = 0; l < 8; l++) begin
                    logic hi_ok, lo_ok, ex_ok;
                    ie_set = (e == 1); ie_clr = (e == 0);
                    mask_we = 1; mask_wdata = 3'(m);
                    req_lvl_hi = l[2]; req_lvl_lo = l[1]; req_ext = l[0];
                    tick();
                    ie_set = 0; ie_clr = 0; mask_we = 0;
                    hi_ok = (e == 1) && !m[1] && l[2];
                    lo_ok = (e == 1) && !m[0] && l[1];
                    ex_ok = (e == 1) && l[0];
                    if (hi_ok)      expect_out("R7", 1, 1, 0, 16'(13 * 4));
                    else if (lo_ok) expect_out("R10", 1, 1, 0, 16'(11 * 4));
                    else if (ex_ok) expect_out("R8", 1, 0, 1, 16'h0);
                    else            expect_out("R9", 0, 0, 0, 16'h0);
                end
            end
        end
        req_lvl_hi = 0; req_lvl_lo = 0; req_ext = 0;

        // Non-maskable behaviour, enable on with everything masked (R2, R3, R11)
        set_mask(3'b111); set_ie(1);
        req_nmi = 1; tick();
        expect_out("R2", 1, 1, 0, 16'h0024);
        req_nmi = 0; tick();
        expect_out("R3", 0, 0, 0, 16'h0);
        req_nmi = 1; tick();
        expect_out("R3", 1, 1, 0, 16'h0024);
        pulse_ack();
        expect_out("R3", 0, 0, 0, 16'h0);   // still high, no fresh edge
        req_ext = 1; tick();
        expect_out("R11", 1, 0, 1, 16'h0);  // enable survived the ack
        req_ext = 0; req_nmi = 0; tick();

        // Priority chain and edge stickiness (R4, R5, R11, R12)
        set_mask(3'b000); set_ie(1);
        req_ext = 1; req_lvl_lo = 1; req_lvl_hi = 1;
        req_edge = 1; tick(); req_edge = 0; tick();
        expect_out("R5", 1, 1, 0, 16'h003C);
        req_nmi = 1; tick();
        expect_out("R4", 1, 1, 0, 16'h0024);
        req_nmi = 0; tick();
        expect_out("R4", 1, 1, 0, 16'h003C);
        pulse_ack();
        expect_out("R11", 0, 0, 0, 16'h0);
        set_ie(1);
        expect_out("R12", 1, 1, 0, 16'h0034);
        req_lvl_hi = 0; tick();
        expect_out("R4", 1, 1, 0, 16'h002C);
        req_lvl_lo = 0; tick();
        expect_out("R4", 1, 0, 1, 16'h0);
        req_ext = 0; tick();
        expect_out("R4", 0, 0, 0, 16'h0);

        // Edge latch captures while blocked; software clear (R6, R12)
        set_mask(3'b111);
        req_edge = 1; tick(); req_edge = 0; tick();
        expect_out("R6", 0, 0, 0, 16'h0);
        set_mask(3'b011);
        expect_out("R6", 1, 1, 0, 16'h003C);
        edge_clr = 1; tick(); edge_clr = 0;
        expect_out("R12", 0, 0, 0, 16'h0);
        set_ie(0);
        req_edge = 1; tick(); req_edge = 0; tick();
        expect_out("R6", 0, 0, 0, 16'h0);
        set_ie(1);
        expect_out("R6", 1, 1, 0, 16'h003C);
        // R1: reset clears the latch, enable and masks again
        rst = 1; tick(); rst = 0; tick();
        expect_out("R1", 0, 0, 0, 16'h0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule